// File: doc/BRIEF.md
# Dual-Channel Supply Control Port over I2C

This block is the serial control port of a two-channel supply controller. It listens on an I2C bus at standard or fast-mode rates and keeps two 8-bit control images, one for each output channel. A host writes a byte, and the byte's own top bit says which channel image it lands in. A host read returns the two images one after the other, with the live fault inputs (overload per channel, over-temperature) merged into their read-only positions.

SCL and SDA are sampled through a synchroniser chain on a system clock that runs at least 20 times faster than SCL. SDA is open-drain: the block only ever pulls it low, through an output-enable. When supply power is not good, the port ignores the bus and holds both images at zero, so both channels stay disabled. An over-temperature condition also clears the stored images.

Top module: `dual_supply_i2c_slave`

## Requirements
- R1: The slave responds to the 7-bit address 0b000100A, where A equals addr_sel_i, followed by an R/W bit (1 = read). On a match it pulls SDA low in the ninth clock. On a mismatch it leaves SDA released and stores nothing.
- R2: Bytes are received MSB first. Every byte written to the slave is acknowledged by a low SDA in its ninth clock.
- R3: A written byte with bit 7 = 0 loads bits 6..1 into channel-1 fields, and ctrl1_o becomes {0, bits 6..1, 0}. With bit 7 = 1 it loads bits 6..2 into channel-2 fields, and ctrl2_o becomes {0, bits 6..2, 00}. Bits in read-only positions are discarded. The images change only on a write or a clear.
- R4: Several data bytes in one write transfer are each steered by their own bit 7.
- R5: After reset both control outputs are zero and SDA is released.
- R6: While pwr_good_i is low the slave never pulls SDA, acknowledges nothing, and both images read as zero.
- R7: A read transfer returns channel 1 first, then channel 2, alternating on each byte the master acknowledges. A master NACK ends the read and releases SDA.
- R8: The channel-1 read byte is {0, fields, ovl1_i}. The channel-2 read byte is {1, fields, ovr_temp_i, ovl2_i}. Status bits are taken live at the moment each byte starts.
- R9: While ovr_temp_i is high both images are held at zero and writes have no effect.
- R10: A START or STOP resets the bit counter. A STOP in the middle of a byte stores nothing, and the next transfer is decoded from its first bit.
- R11: The slave changes SDA only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Selects the address LSB |
| pwr_good_i | input | 1 | Supply good; low silences and clears |
| ovr_temp_i | input | 1 | Over-temperature fault |
| ovl1_i | input | 1 | Channel-1 overload status |
| ovl2_i | input | 1 | Channel-2 overload status |
| ctrl1_o | output | 8 | Channel-1 control image |
| ctrl2_o | output | 8 | Channel-2 control image |

## Verification
The bench builds the block with a three-stage synchroniser instead of the default two. This puts the SDA updates several system clocks after each SCL edge, so the SCL-low rule on SDA changes is tested with real latency. The address base stays at its default. The bench flips addr_sel_i both ways, so both pin-selected addresses are matched and each one is also refused when the pin selects the other. SCL runs 80 system clocks per bit, which puts START, STOP and mid-byte aborts well inside the sampling margin.

// File: rtl/lnb_i2c_pkg.sv
package lnb_i2c_pkg;
   localparam int BYTE_W = 8;
   localparam int CH1_FIELDS = BYTE_W - 2;
   localparam int CH2_FIELDS = BYTE_W - 3;

   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_ADDR,
      BUS_AACK,
      BUS_WDATA,
      BUS_WACK,
      BUS_RDATA,
      BUS_RACK
   } bus_state_t;
endpackage

// File: rtl/lnb_i2c_sync.sv
module lnb_i2c_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("lnb_i2c_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else if (s == 0) chain[s] <= d_i;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lnb_i2c_bus.sv
module lnb_i2c_bus
   import lnb_i2c_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE = 7'b0001000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              addr_sel,
   input  logic              pwr_good,
   input  logic [BYTE_W-1:0] img1,
   input  logic [BYTE_W-1:0] img2,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   bus_state_t        st;
   logic              scl_p, sda_p;
   logic [BYTE_W-2:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [CNT_W-1:0]  cnt;
   logic              byte_done, hit, rw, rd_sel, mack;
   logic [6:0]        my_addr;
   logic [BYTE_W-1:0] nxt;
   logic              scl_rise, scl_fall, bus_start, bus_stop;

   assign my_addr   = {ADDR_BASE[6:1], addr_sel};
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
   assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
   assign nxt       = rd_sel ? img2 : img1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= BUS_IDLE;
         sh        <= '0;
         tx        <= '0;
         cnt       <= '0;
         byte_done <= 1'b0;
         hit       <= 1'b0;
         rw        <= 1'b0;
         rd_sel    <= 1'b0;
         mack      <= 1'b0;
         sda_oe    <= 1'b0;
         wr_stb    <= 1'b0;
         wr_byte   <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (!pwr_good) begin
            st        <= BUS_IDLE;
            sda_oe    <= 1'b0;
            cnt       <= '0;
            byte_done <= 1'b0;
         end else if (bus_start) begin
            st        <= BUS_ADDR;
            sda_oe    <= 1'b0;
            cnt       <= '0;
            byte_done <= 1'b0;
         end else if (bus_stop) begin
            st        <= BUS_IDLE;
            sda_oe    <= 1'b0;
            cnt       <= '0;
            byte_done <= 1'b0;
         end else begin
            unique case (st)
               BUS_IDLE: ;
               BUS_ADDR: begin
                  if (scl_rise && !byte_done) begin
                     sh <= {sh[BYTE_W-3:0], sda_s};
                     if (cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        hit       <= (sh == my_addr);
                        rw        <= sda_s;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (scl_fall && byte_done) begin
                     byte_done <= 1'b0;
                     cnt       <= '0;
                     if (hit) begin
                        st     <= BUS_AACK;
                        sda_oe <= 1'b1;
                     end else begin
                        st <= BUS_IDLE;
                     end
                  end
               end
               BUS_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        st     <= BUS_RDATA;
                        tx     <= img1;
                        sda_oe <= ~img1[BYTE_W-1];
                        rd_sel <= 1'b1;
                     end else begin
                        st     <= BUS_WDATA;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               BUS_WDATA: begin
                  if (scl_rise && !byte_done) begin
                     sh <= {sh[BYTE_W-3:0], sda_s};
                     if (cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        wr_stb    <= 1'b1;
                        wr_byte   <= {sh, sda_s};
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (scl_fall && byte_done) begin
                     byte_done <= 1'b0;
                     cnt       <= '0;
                     st        <= BUS_WACK;
                     sda_oe    <= 1'b1;
                  end
               end
               BUS_WACK: begin
                  if (scl_fall) begin
                     st     <= BUS_WDATA;
                     sda_oe <= 1'b0;
                  end
               end
               BUS_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        st     <= BUS_RACK;
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                     end else begin
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               BUS_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st     <= BUS_RDATA;
                        tx     <= nxt;
                        sda_oe <= ~nxt[BYTE_W-1];
                        rd_sel <= ~rd_sel;
                     end else begin
                        st <= BUS_IDLE;
                     end
                  end
               end
               default: st <= BUS_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/lnb_i2c_regs.sv
module lnb_i2c_regs
   import lnb_i2c_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              ovr_temp,
   input  logic              ovl1,
   input  logic              ovl2,
   output logic [BYTE_W-1:0] img1,
   output logic [BYTE_W-1:0] img2,
   output logic [BYTE_W-1:0] ctrl1,
   output logic [BYTE_W-1:0] ctrl2
);
   logic [CH1_FIELDS-1:0] f1;
   logic [CH2_FIELDS-1:0] f2;
   logic                  unused_lsb;

   assign unused_lsb = wr_byte[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1 <= '0;
         f2 <= '0;
      end else if (clear) begin
         f1 <= '0;
         f2 <= '0;
      end else if (wr_stb) begin
         if (wr_byte[BYTE_W-1]) f2 <= wr_byte[BYTE_W-2:2];
         else                   f1 <= wr_byte[BYTE_W-2:1];
      end
   end

   assign img1  = {1'b0, f1, ovl1};
   assign img2  = {1'b1, f2, ovr_temp, ovl2};
   assign ctrl1 = {1'b0, f1, 1'b0};
   assign ctrl2 = {1'b0, f2, 2'b00};
endmodule

// File: rtl/dual_supply_i2c_slave.sv
module dual_supply_i2c_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_BASE   = 7'b0001000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic       addr_sel_i,
   input  logic       pwr_good_i,
   input  logic       ovr_temp_i,
   input  logic       ovl1_i,
   input  logic       ovl2_i,
   output logic [7:0] ctrl1_o,
   output logic [7:0] ctrl2_o
);
   import lnb_i2c_pkg::*;

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("dual_supply_i2c_slave: byte width must be 8");
      end
   endgenerate

   logic [1:0]        line_s;
   logic              scl_s, sda_s;
   logic              wr_stb;
   logic [BYTE_W-1:0] wr_byte, img1, img2;
   logic              clear;

   lnb_i2c_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({scl_i, sda_i}),
      .q_o  (line_s)
   );
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   lnb_i2c_bus #(.ADDR_BASE(ADDR_BASE)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (scl_s),
      .sda_s   (sda_s),
      .addr_sel(addr_sel_i),
      .pwr_good(pwr_good_i),
      .img1    (img1),
      .img2    (img2),
      .sda_oe  (sda_oe_o),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte)
   );

   assign clear = ~pwr_good_i | ovr_temp_i;

   lnb_i2c_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte),
      .ovr_temp(ovr_temp_i),
      .ovl1    (ovl1_i),
      .ovl2    (ovl2_i),
      .img1    (img1),
      .img2    (img2),
      .ctrl1   (ctrl1_o),
      .ctrl2   (ctrl2_o)
   );
endmodule

// File: rtl/dual_supply_i2c_slave_chk.sv
module dual_supply_i2c_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_good_i,
   input logic       ovr_temp_i,
   input logic       scl_s,
   input logic       sda_oe_o,
   input logic       wr_stb,
   input logic [7:0] ctrl1_o,
   input logic [7:0] ctrl2_o
);
   p_silent_unpowered_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good_i |=> (!sda_oe_o && ctrl1_o == 8'h00 && ctrl2_o == 8'h00));

   p_hot_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_temp_i |=> (ctrl1_o == 8'h00 && ctrl2_o == 8'h00));

   p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_s);

   p_images_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good_i && !ovr_temp_i && !wr_stb) |=> ($stable(ctrl1_o) && $stable(ctrl2_o)));

   p_oe_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> $past(pwr_good_i));
endmodule

bind dual_supply_i2c_slave dual_supply_i2c_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_good_i(pwr_good_i),
   .ovr_temp_i(ovr_temp_i),
   .scl_s     (scl_s),
   .sda_oe_o  (sda_oe_o),
   .wr_stb    (wr_stb),
   .ctrl1_o   (ctrl1_o),
   .ctrl2_o   (ctrl2_o)
);

// File: tb/dual_supply_i2c_slave_test.sv
`timescale 1ns/1ps
module dual_supply_i2c_slave_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       addr_sel = 1'b0;
   logic       pwr_good = 1'b1;
   logic       ovr_temp = 1'b0;
   logic       ovl1 = 1'b0;
   logic       ovl2 = 1'b0;
   logic       sda_oe;
   logic       sda_bus;
   logic [7:0] ctrl1, ctrl2;

   int vectors = 0;
   int miscompares = 0;
   int scl_high_moves = 0;
   logic oe_prev = 1'b0;
   bit  finished = 1'b0;

   localparam int Q = 20;

   always #2 clk = ~clk;

   assign sda_bus = ~(m_low | sda_oe);

   dual_supply_i2c_slave #(.SYNC_STAGES(3)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_bus),
      .sda_oe_o  (sda_oe),
      .addr_sel_i(addr_sel),
      .pwr_good_i(pwr_good),
      .ovr_temp_i(ovr_temp),
      .ovl1_i    (ovl1),
      .ovl2_i    (ovl2),
      .ctrl1_o   (ctrl1),
      .ctrl2_o   (ctrl2)
   );

   // R11 monitor: SDA may only move while SCL is low
   always @(posedge clk) begin
      if (rst_n && sda_oe !== oe_prev && scl) scl_high_moves++;
      oe_prev <= sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b1; tick(Q);
      scl = 1'b0;
   endtask

   task automatic bus_stop();
      tick(Q); m_low = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      m_low = 1'b0; tick(Q);
   endtask

   // one clock: drive (or release) SDA, return the bus level sampled mid-high
   task automatic bus_bit(input logic drive_low, output logic seen);
      tick(Q); m_low = drive_low; tick(Q);
      scl = 1'b1; tick(Q);
      seen = sda_bus; tick(Q);
      scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(~b[i], s);
      bus_bit(1'b0, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b0, s);
         b[i] = s;
      end
      bus_bit(give_ack, s);
   endtask

   task automatic t_reset();
      chk("R5 ctrl1 after reset", ctrl1, 8'h00);
      chk("R5 ctrl2 after reset", ctrl2, 8'h00);
      chk("R5 sda released", {7'd0, sda_oe}, 8'h00);
   endtask

   task automatic t_write_each();
      logic a;
      bus_start();
      send_byte(8'h10, a); chk("R1 address ack", {7'd0, a}, 8'h01);
      send_byte(8'h55, a); chk("R2 data ack", {7'd0, a}, 8'h01);
      bus_stop();
      chk("R3 ch1 fields", ctrl1, 8'h54);
      chk("R3 ch2 untouched", ctrl2, 8'h00);
      bus_start();
      send_byte(8'h10, a);
      send_byte(8'hB7, a); chk("R2 data ack ch2", {7'd0, a}, 8'h01);
      bus_stop();
      chk("R3 ch2 fields", ctrl2, 8'h34);
      chk("R3 ch1 kept", ctrl1, 8'h54);
   endtask

   task automatic t_multi();
      logic a;
      bus_start();
      send_byte(8'h10, a);
      send_byte(8'h2A, a);
      send_byte(8'hC8, a); chk("R4 second byte ack", {7'd0, a}, 8'h01);
      bus_stop();
      chk("R4 ch1 from first byte", ctrl1, 8'h2A);
      chk("R4 ch2 from second byte", ctrl2, 8'h48);
   endtask

   task automatic t_wrong_addr();
      logic a;
      bus_start();
      send_byte(8'h12, a); chk("R1 foreign address nack", {7'd0, a}, 8'h00);
      send_byte(8'h00, a); chk("R1 no data ack", {7'd0, a}, 8'h00);
      bus_stop();
      chk("R1 ch1 unchanged", ctrl1, 8'h2A);
      chk("R1 ch2 unchanged", ctrl2, 8'h48);
   endtask

   task automatic t_addr_pin();
      logic a;
      addr_sel = 1'b1; tick(4);
      bus_start();
      send_byte(8'h10, a); chk("R1 base address refused with pin high", {7'd0, a}, 8'h00);
      bus_stop();
      bus_start();
      send_byte(8'h12, a); chk("R1 pin address ack", {7'd0, a}, 8'h01);
      send_byte(8'h7F, a);
      bus_stop();
      chk("R1 write via pin address", ctrl1, 8'h7E);
      addr_sel = 1'b0; tick(4);
   endtask

   task automatic t_read();
      logic a;
      logic [7:0] b;
      ovl1 = 1'b1; ovl2 = 1'b0;
      bus_start();
      send_byte(8'h11, a); chk("R1 read address ack", {7'd0, a}, 8'h01);
      recv_byte(1'b1, b); chk("R8 ch1 image with overload", b, 8'h7F);
      ovl2 = 1'b1;
      recv_byte(1'b1, b); chk("R7 second byte is ch2 (R8 live ovl2)", b, 8'hC9);
      recv_byte(1'b0, b); chk("R7 third byte back to ch1", b, 8'h7F);
      tick(Q);
      chk("R7 released after nack", {7'd0, sda_oe}, 8'h00);
      bus_stop();
      ovl1 = 1'b0; ovl2 = 1'b0;
   endtask

   task automatic t_abort();
      logic a, s;
      bus_start();
      send_byte(8'h10, a);
      for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
      bus_stop();
      chk("R10 aborted byte ch1", ctrl1, 8'h7E);
      chk("R10 aborted byte ch2", ctrl2, 8'h48);
      bus_start();
      send_byte(8'h10, a); chk("R10 fresh transfer ack", {7'd0, a}, 8'h01);
      send_byte(8'h02, a);
      bus_stop();
      chk("R10 fresh write lands", ctrl1, 8'h02);
   endtask

   task automatic t_overtemp();
      logic a;
      logic [7:0] b;
      ovl1 = 1'b1;
      ovr_temp = 1'b1; tick(4);
      chk("R9 ch1 cleared", ctrl1, 8'h00);
      chk("R9 ch2 cleared", ctrl2, 8'h00);
      bus_start();
      send_byte(8'h10, a);
      send_byte(8'h7F, a);
      bus_stop();
      chk("R9 write ignored while hot", ctrl1, 8'h00);
      bus_start();
      send_byte(8'h11, a);
      recv_byte(1'b1, b); chk("R8 ch1 image hot", b, 8'h01);
      recv_byte(1'b0, b); chk("R8 ch2 image shows over-temp", b, 8'h82);
      bus_stop();
      ovr_temp = 1'b0; ovl1 = 1'b0; tick(4);
   endtask

   task automatic t_unpowered();
      logic a;
      bus_start();
      send_byte(8'h10, a);
      send_byte(8'h02, a);
      send_byte(8'h84, a);
      bus_stop();
      chk("R6 precondition ch1", ctrl1, 8'h02);
      pwr_good = 1'b0; tick(4);
      chk("R6 ch1 zero unpowered", ctrl1, 8'h00);
      chk("R6 ch2 zero unpowered", ctrl2, 8'h00);
      bus_start();
      send_byte(8'h10, a); chk("R6 no ack unpowered", {7'd0, a}, 8'h00);
      send_byte(8'h7F, a); chk("R6 no data ack unpowered", {7'd0, a}, 8'h00);
      bus_stop();
      chk("R6 write dropped", ctrl1, 8'h00);
      pwr_good = 1'b1; tick(4);
      bus_start();
      send_byte(8'h10, a); chk("R6 ack after power returns", {7'd0, a}, 8'h01);
      bus_stop();
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(10);
      t_reset();
      t_write_each();
      t_multi();
      t_wrong_addr();
      t_addr_pin();
      t_read();
      t_abort();
      t_overtemp();
      t_unpowered();
      chk("R11 sda moved while scl high", scl_high_moves[7:0], 8'h00);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule